// File: doc/BRIEF.md
# Half-Precision Reciprocal Estimator

This block takes one IEEE 754 binary16 operand per cycle and returns a coarse approximation of its reciprocal two clock cycles later. Special encodings are handled in a fixed order of precedence: NaN, infinity, zero, operands too small to have a finite reciprocal, and operands large enough that the reciprocal is flushed. Every returned value comes with the exception flags that it raises. It serves as the seed stage of an iterative divide or reciprocal sequence, where later refinement steps supply the missing accuracy.

Four per-operation controls go in with the operand: flush of denormal inputs, flush-to-zero of results, default-NaN substitution and a two-bit rounding mode. Only the too-small path uses the rounding mode. The pipeline accepts a new operand every cycle.

Top module: `hp_recip_est`

## Requirements
- R1: `out_valid` is high exactly two rising edges after an edge that samples `in_valid` high, and is low otherwise, including at reset. Back-to-back operands come out on back-to-back cycles. After reset `out_res` and `out_flags` are zero.
- R2: The operand is split into sign (bit 15), biased exponent (bits 14:10) and fraction (bits 9:0). A NaN (exponent 31, fraction non-zero) is returned with fraction bit 9 forced to 1. If fraction bit 9 was 0 (signaling), invalid (`out_flags[0]`) is raised. No other flag is raised.
- R3: With `cfg_dnan` set, every NaN input returns 0x7E00. Invalid is still raised for a signaling input.
- R4: An infinite input returns a zero with the input's sign, and no flag is raised.
- R5: A zero input returns an infinity (0x7C00) with the input's sign and raises only divide-by-zero (`out_flags[1]`).
- R6: With `cfg_flush_in` set, a denormal input (exponent 0, fraction non-zero) is treated as a zero of the same sign. It follows the R5 path.
- R7: A non-zero finite input whose bits 14:0 are below 0x0100 raises overflow (`out_flags[2]`) and inexact (`out_flags[4]`). Rounding modes are 00 nearest, 01 toward plus, 10 toward minus, 11 toward zero. The block returns a signed infinity when the mode is nearest, or when the mode is toward plus with a positive sign, or toward minus with a negative sign. Otherwise it returns the signed largest finite value (magnitude 0x7BFF).
- R8: With `cfg_ftz` set, a finite input with biased exponent of 29 or more returns a zero of the input's sign and raises underflow (`out_flags[3]`) and inexact.
- R9: Any other input returns a finite value with the input's sign and no flags. Its value lies within 1/128 of the true reciprocal, relative, plus 2^-24 absolute. Denormal inputs are normalised first.
- R10: With `cfg_ftz` clear, inputs with biased exponent 29 or 30 produce subnormal results (exponent field 0) that still meet the R9 accuracy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 16 | binary16 operand |
| cfg_flush_in | input | 1 | Treat denormal inputs as zero |
| cfg_ftz | input | 1 | Flush results that would be subnormal |
| cfg_dnan | input | 1 | Return default NaN for any NaN |
| cfg_rmode | input | 2 | Rounding mode: 00 nearest, 01 plus, 10 minus, 11 zero |
| out_valid | output | 1 | Result strobe |
| out_res | output | 16 | binary16 reciprocal estimate |
| out_flags | output | 5 | {inexact, underflow, overflow, div-by-zero, invalid} |

## Verification
The hardest inputs to reach are the denormal operands at the edge of the too-small test (0x00FF against 0x0100), and the operands with exponent 29 or 30 whose result turns subnormal when result flushing is off. Uniform random 16-bit operands almost never hit these. The bench applies them as directed cases under every control setting. It also biases part of the random stream toward exponents 0, 29, 30 and 31. Each normal result is compared in real arithmetic against the true reciprocal, not against a bit pattern.

// File: rtl/hpre_pkg.sv
`timescale 1ns/1ps
package hpre_pkg;
  localparam int FW   = 10;
  localparam int EW   = 5;
  localparam int BIAS = 15;
  localparam int NFLG = 5;
  localparam int F_INV = 0;
  localparam int F_DZ  = 1;
  localparam int F_OVF = 2;
  localparam int F_UNF = 3;
  localparam int F_INX = 4;

  typedef enum logic [2:0] {
    CL_NAN, CL_INF, CL_ZERO, CL_TINY, CL_HUGE, CL_NORM
  } cls_t;

  // rounding mode: 00 nearest, 01 toward +, 10 toward -, 11 toward zero
  function automatic logic goes_to_inf(input logic [1:0] rm, input logic sgn);
    case (rm)
      2'b00:   return 1'b1;
      2'b01:   return !sgn;
      2'b10:   return sgn;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/hpre_classify.sv
`timescale 1ns/1ps
module hpre_classify
  import hpre_pkg::*;
(
  input  logic [15:0]       op,
  input  logic              flush_in,
  input  logic              ftz,
  output cls_t              cls,
  output logic              snan,
  output logic signed [6:0] eff_exp,
  output logic [FW-1:0]     nfrac
);
  localparam logic [EW-1:0] EMAX     = '1;
  localparam int            HUGE_EXP = 2 * BIAS - 1;

  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  logic          is_den, is_zero, is_nan, is_inf, is_tiny, is_huge;
  logic [3:0]    lead;

  assign ex = op[14:10];
  assign fr = op[FW-1:0];

  assign is_den  = (ex == '0) && (fr != '0);
  assign is_zero = (ex == '0) && ((fr == '0) || flush_in);
  assign is_nan  = (ex == EMAX) && (fr != '0);
  assign is_inf  = (ex == EMAX) && (fr == '0);
  assign is_tiny = !is_zero && (op[14:0] < 15'h0100);
  assign is_huge = ftz && (int'(ex) >= HUGE_EXP);
  assign snan    = is_nan && !fr[FW-1];

  always_comb begin
    if (is_nan)       cls = CL_NAN;
    else if (is_inf)  cls = CL_INF;
    else if (is_zero) cls = CL_ZERO;
    else if (is_tiny) cls = CL_TINY;
    else if (is_huge) cls = CL_HUGE;
    else              cls = CL_NORM;
  end

  // leading one of a denormal fraction
  always_comb begin
    lead = '0;
    for (int i = 0; i < FW; i++)
      if (fr[i]) lead = 4'(i);
  end

  always_comb begin
    if (is_den) begin
      nfrac   = fr << (FW - int'(lead));
      eff_exp = 7'(int'(lead) - (FW - 1));
    end else begin
      nfrac   = fr;
      eff_exp = 7'(int'(ex));
    end
  end

  always_comb begin
    if (is_nan) assert_nan_first_R2: assert (cls == CL_NAN);
  end
endmodule

// File: rtl/hpre_estimate.sv
`timescale 1ns/1ps
module hpre_estimate
  import hpre_pkg::*;
#(
  parameter int EST_W = 8
) (
  input  logic              sgn,
  input  logic signed [6:0] eff_exp,
  input  logic [FW-1:0]     nfrac,
  output logic [15:0]       res
);
  localparam int RBASE = 2 * BIAS - 1;

  // reciprocal of the interval midpoint, EST_W+1 bits with leading one
  function automatic logic [EST_W:0] recip_sig(input logic [FW-1:0] nf);
    int unsigned den, num;
    den = 2 * ((32'd1 << EST_W) + (32'(nf) >> (FW - EST_W))) + 1;
    num = 32'd1 << (2 * EST_W + 2);
    return (EST_W + 1)'(num / den);
  endfunction

  logic [EST_W:0] q;
  logic [FW:0]    sig;
  logic [FW-1:0]  sub;
  int             rexp;

  assign q = recip_sig(nfrac);

  always_comb begin
    sig = '0;
    sig[FW -: EST_W + 1] = q;
    rexp = RBASE - int'(eff_exp);
    sub  = '0;
    if (rexp >= 1) begin
      res = {sgn, 5'(rexp), sig[FW-1:0]};
    end else begin
      sub = FW'(sig >> (1 - rexp));
      res = {sgn, 5'b0, sub};
    end
  end

  always_comb begin
    assert_est_lead_R9: assert (q[EST_W] === 1'b1 || $isunknown(nfrac));
  end
endmodule

// File: rtl/hp_recip_est.sv
`timescale 1ns/1ps
module hp_recip_est
  import hpre_pkg::*;
#(
  parameter int EST_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_op,
  input  logic        cfg_flush_in,
  input  logic        cfg_ftz,
  input  logic        cfg_dnan,
  input  logic [1:0]  cfg_rmode,
  output logic        out_valid,
  output logic [15:0] out_res,
  output logic [4:0]  out_flags
);
  localparam logic [15:0] DEF_NAN = 16'h7E00;
  localparam logic [14:0] INF_MAG = 15'h7C00;
  localparam logic [14:0] MAX_MAG = 15'h7BFF;

  // stage 1: decode
  cls_t              c_cls;
  logic              c_snan;
  logic signed [6:0] c_eff;
  logic [FW-1:0]     c_nfrac;

  hpre_classify u_cls (
    .op(in_op), .flush_in(cfg_flush_in), .ftz(cfg_ftz),
    .cls(c_cls), .snan(c_snan), .eff_exp(c_eff), .nfrac(c_nfrac)
  );

  logic              s1_valid, s1_snan, s1_dnan;
  cls_t              s1_cls;
  logic [15:0]       s1_op;
  logic [1:0]        s1_rm;
  logic signed [6:0] s1_eff;
  logic [FW-1:0]     s1_nfrac;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_snan  <= 1'b0;
      s1_dnan  <= 1'b0;
      s1_cls   <= CL_ZERO;
      s1_op    <= '0;
      s1_rm    <= '0;
      s1_eff   <= '0;
      s1_nfrac <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_snan  <= c_snan;
        s1_dnan  <= cfg_dnan;
        s1_cls   <= c_cls;
        s1_op    <= in_op;
        s1_rm    <= cfg_rmode;
        s1_eff   <= c_eff;
        s1_nfrac <= c_nfrac;
      end
    end
  end

  // stage 2: estimate and select
  logic [15:0] est_res;

  hpre_estimate #(.EST_W(EST_W)) u_est (
    .sgn(s1_op[15]), .eff_exp(s1_eff), .nfrac(s1_nfrac), .res(est_res)
  );

  logic [15:0]     n_res;
  logic [NFLG-1:0] n_flg;
  logic            sgn;

  assign sgn = s1_op[15];

  always_comb begin
    n_flg = '0;
    unique case (s1_cls)
      CL_NAN: begin
        n_res        = s1_dnan ? DEF_NAN : (s1_op | 16'h0200);
        n_flg[F_INV] = s1_snan;
      end
      CL_INF:  n_res = {sgn, 15'h0};
      CL_ZERO: begin
        n_res       = {sgn, INF_MAG};
        n_flg[F_DZ] = 1'b1;
      end
      CL_TINY: begin
        n_res        = goes_to_inf(s1_rm, sgn) ? {sgn, INF_MAG} : {sgn, MAX_MAG};
        n_flg[F_OVF] = 1'b1;
        n_flg[F_INX] = 1'b1;
      end
      CL_HUGE: begin
        n_res        = {sgn, 15'h0};
        n_flg[F_UNF] = 1'b1;
        n_flg[F_INX] = 1'b1;
      end
      default: n_res = est_res;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_res   <= n_res;
        out_flags <= n_flg;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);
  assert_invalid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[F_INV]) |-> (out_res[14:9] == 6'h3F));
  assert_default_nan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_cls == CL_NAN && s1_dnan) |=> (out_res == DEF_NAN));
  assert_dz_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[F_DZ]) |-> (out_res[14:0] == INF_MAG));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[F_OVF]) |->
      (out_flags[F_INX] && (out_res[14:0] == INF_MAG || out_res[14:0] == MAX_MAG)));
  assert_flush_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flags[F_UNF]) |-> (out_flags[F_INX] && out_res[14:0] == 15'h0));
  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_flags[3:0]));
endmodule

// File: tb/sim_hp_recip_est.sv
`timescale 1ns/1ps
module sim_hp_recip_est;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_op = '0;
  logic        cfg_flush_in = 1'b0, cfg_ftz = 1'b0, cfg_dnan = 1'b0;
  logic [1:0]  cfg_rmode = 2'b00;
  logic        out_valid;
  logic [15:0] out_res;
  logic [4:0]  out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hp_recip_est u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .cfg_flush_in(cfg_flush_in), .cfg_ftz(cfg_ftz), .cfg_dnan(cfg_dnan),
    .cfg_rmode(cfg_rmode), .out_valid(out_valid), .out_res(out_res),
    .out_flags(out_flags)
  );

  function automatic real hval(input logic [14:0] m);
    int e = int'(m[14:10]);
    int f = int'(m[9:0]);
    if (e == 0) return real'(f) * (2.0 ** (-24));
    return real'(1024 + f) * (2.0 ** (e - 25));
  endfunction

  task automatic report(input string tag, input bit ok,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s op=%h act=%h exp=%h", tag, in_op, act, exp);
    end
  endtask

  // expected result from the requirements; norm=1 means accuracy check
  task automatic expect_of(input logic [15:0] op, output bit norm,
                           output logic [15:0] er, output logic [4:0] ef,
                           output string tag);
    logic s = op[15];
    int e = int'(op[14:10]);
    logic [9:0] f = op[9:0];
    norm = 0; er = '0; ef = '0;
    if (e == 31 && f != 0) begin
      er = cfg_dnan ? 16'h7E00 : (op | 16'h0200);
      ef = {4'b0, !f[9]};
      tag = cfg_dnan ? "R3" : "R2";
    end else if (e == 31) begin
      er = {s, 15'h0}; tag = "R4";
    end else if (e == 0 && (f == 0 || cfg_flush_in)) begin
      er = {s, 15'h7C00}; ef = 5'b00010;
      tag = (f == 0) ? "R5" : "R6";
    end else if (op[14:0] < 15'h0100) begin
      bit up = (cfg_rmode == 2'b00) || (cfg_rmode == 2'b01 && !s)
            || (cfg_rmode == 2'b10 && s);
      er = up ? {s, 15'h7C00} : {s, 15'h7BFF};
      ef = 5'b10100; tag = "R7";
    end else if (cfg_ftz && e >= 29) begin
      er = {s, 15'h0}; ef = 5'b11000; tag = "R8";
    end else begin
      norm = 1;
      tag = (e >= 29) ? "R10" : "R9";
    end
  endtask

  task automatic check_out(input logic [15:0] op);
    bit norm;
    logic [15:0] er;
    logic [4:0] ef;
    string tag;
    expect_of(op, norm, er, ef, tag);
    report("R1 valid", out_valid === 1'b1, 32'(out_valid), 32'h1);
    if (!norm) begin
      report(tag, out_res === er && out_flags === ef,
             {11'h0, out_flags, out_res}, {11'h0, ef, er});
    end else begin
      real r = 1.0 / hval(op[14:0]);
      real g = hval(out_res[14:0]);
      real d = (g > r) ? g - r : r - g;
      bit ok = (d <= r / 128.0 + 2.0 ** (-24)) && out_res[15] == op[15]
            && out_flags == 5'b0 && out_res[14:10] != 5'h1F;
      if (tag == "R10") ok = ok && out_res[14:10] == 5'h0;
      report(tag, ok, {11'h0, out_flags, out_res}, {16'h0, op});
    end
  endtask

  task automatic run_one(input logic [15:0] op, input bit fin, input bit ftz,
                         input bit dn, input logic [1:0] rm);
    @(negedge clk);
    in_valid = 1; in_op = op; cfg_flush_in = fin; cfg_ftz = ftz;
    cfg_dnan = dn; cfg_rmode = rm;
    @(negedge clk);
    in_valid = 0;
    report("R1 latency", out_valid === 1'b0, 32'(out_valid), 32'h0);
    @(negedge clk);
    check_out(op);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    report("R1 reset", out_valid === 0 && out_res === 0 && out_flags === 0,
           {11'h0, out_flags, out_res}, 32'h0);
    rst_n = 1;

    // directed corners
    run_one(16'h7C01, 0, 0, 0, 2'b00);   // R2 signaling
    run_one(16'hFE05, 0, 0, 0, 2'b00);   // R2 quiet
    run_one(16'h7C01, 0, 0, 1, 2'b00);   // R3
    run_one(16'h7E00, 0, 0, 1, 2'b11);   // R3
    run_one(16'h7C00, 0, 1, 0, 2'b00);   // R4
    run_one(16'hFC00, 0, 0, 0, 2'b10);   // R4
    run_one(16'h0000, 0, 0, 0, 2'b00);   // R5
    run_one(16'h8000, 0, 0, 0, 2'b00);   // R5
    run_one(16'h83FF, 1, 0, 0, 2'b00);   // R6
    run_one(16'h0001, 1, 0, 0, 2'b11);   // R6
    for (int m = 0; m < 4; m++) begin
      run_one(16'h00FF, 0, 0, 0, 2'(m)); // R7
      run_one(16'h8001, 0, 0, 0, 2'(m)); // R7
    end
    run_one(16'h0100, 0, 0, 0, 2'b11);   // R9 boundary
    run_one(16'h03FF, 0, 0, 0, 2'b00);   // R9 denormal
    run_one(16'h7400, 0, 1, 0, 2'b00);   // R8 exp 29
    run_one(16'hFBFF, 0, 1, 0, 2'b00);   // R8 exp 30
    run_one(16'h73FF, 0, 1, 0, 2'b00);   // R9 exp 28
    run_one(16'h7400, 0, 0, 0, 2'b00);   // R10
    run_one(16'hFBFF, 0, 0, 0, 2'b00);   // R10
    run_one(16'h3C00, 0, 0, 0, 2'b00);   // R9
    for (int e = 1; e < 31; e++)
      for (int k = 0; k < 8; k++)
        run_one({1'(k), 5'(e), 10'(k * 131)}, 0, 0, 0, 2'b00); // R9 sweep

    // R1 back-to-back
    @(negedge clk);
    in_valid = 1; in_op = 16'h3C00; cfg_flush_in = 0; cfg_ftz = 0; cfg_dnan = 0;
    @(negedge clk);
    in_op = 16'hC000;
    @(negedge clk);
    in_valid = 0;
    in_op = 16'h3C00; check_out(16'h3C00);
    @(negedge clk);
    in_op = 16'hC000; check_out(16'hC000);
    @(negedge clk);
    report("R1 drop", out_valid === 1'b0, 32'(out_valid), 32'h0);

    // random, biased toward edge exponents
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] op = 16'($urandom);
      int sel = int'($urandom % 4);
      if (sel == 0) op[14:10] = 5'h00;
      else if (sel == 1) op[14:10] = 5'd29 + 5'($urandom % 3);
      run_one(op, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule